// File: doc/BRIEF.md
# Serial Chain Output Expander Driver

This block drives a chain of serial-in, parallel-out latch devices so that three wires give a processor extra output pins. The user presents a parallel word and pulses a start strobe. The block sends the word on a serial data line, most significant bit first, beside a shift clock that it derives from the system clock. After the last bit it raises a separate latch line, and the chain then presents the new value on its parallel outputs.

The chain's cascade output can be wired back to the block's serial input. In that case the block samples that line on every rising shift clock edge. The word it assembles is the value the chain held before this transfer. That word appears on a read port together with a one-cycle done pulse.

The chain length is a parameter counted in 8-bit devices. The shift clock half period is a second parameter, counted in system clock cycles. Values below two are raised to two.

Top module: `spi_chain_driver`

## Requirements
- R1: While reset is asserted and after it is released, sck_o, lat_o, busy_o and done_o are low and rdata_o is zero.
- R2: A start strobe seen while idle sends W = 8*N_DEV bits, giving exactly W rising sck_o edges. Bits go out most significant first, so a chain that shifts sdo_o into its bit 0 on each rising edge holds data_i once the transfer ends.
- R3: sdo_o changes only while sck_o is low. It is stable in the cycle where sck_o rises and for the whole high phase.
- R4: sck_o is low while idle. Each of its phases during a transfer lasts exactly HALF_CYC system cycles. The first rising edge comes HALF_CYC cycles after busy_o rises.
- R5: Each transfer gives one rising edge on lat_o. That edge comes after the W-th falling sck_o edge, while sck_o is low, and lat_o then stays high for exactly HALF_CYC cycles.
- R6: busy_o rises in the cycle after an accepted start and stays high until the latch pulse ends. A start strobe seen while busy_o is high has no effect: the chain is left holding the first word and only one done pulse occurs.
- R7: rdata_o is built from sdi_i sampled at each rising sck_o edge, with the first sample in the MSB. With the cascade wired back, it equals the word the chain held before the transfer (zero after power-up). It changes only together with done_o.
- R8: done_o is high for exactly one cycle per transfer. That cycle is the one in which lat_o falls and busy_o goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when idle |
| data_i | input | 8*N_DEV | Word to send, sampled with the accepted start |
| sdi_i | input | 1 | Serial return from the chain's cascade output |
| sdo_o | output | 1 | Serial data to the chain |
| sck_o | output | 1 | Generated shift clock, idles low |
| lat_o | output | 1 | Latch clock to the chain |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when a transfer ends |
| rdata_o | output | 8*N_DEV | Previous chain contents read back |

## Verification
A bit counter that is off by one shows at the ports within one transfer. The number of sck_o rising edges is wrong, lat_o rises at the wrong count, and the latched chain value comes out shifted. A divider fault changes the measured phase length from the first edge on. A fault in the shift register that makes data change while sck_o is high corrupts the chain at the next rising edge and shows in the latched word. A broken capture path shows up as a wrong readback word on the transfer after the chain was loaded.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_PRE,
    ST_LATCH
  } seq_state_e;
endpackage

// File: rtl/spi_chain_tick.sv
module spi_chain_tick #(
  parameter int unsigned HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned HALF_EFF = (HALF < 2) ? 2 : HALF;
  localparam int unsigned CW = $clog2(HALF_EFF);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF_EFF - 1));

  // counter restarts whenever the sequencer goes idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_chain_seq.sv
module spi_chain_seq
  import spi_chain_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic sck_o,
  output logic lat_o,
  output logic done_o,
  output logic load_o,
  output logic capture_o,
  output logic shift_o,
  output logic commit_o
);
  localparam int unsigned BW = $clog2(W);

  seq_state_e    state_q;
  logic [BW-1:0] bit_q;
  logic          sck_q, lat_q, done_q;

  assign busy_o    = (state_q != ST_IDLE);
  assign load_o    = (state_q == ST_IDLE)  && start_i;
  assign capture_o = (state_q == ST_LOW)   && tick_i;
  assign shift_o   = (state_q == ST_HIGH)  && tick_i;
  assign commit_o  = (state_q == ST_LATCH) && tick_i;
  assign sck_o     = sck_q;
  assign lat_o     = lat_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sck_q   <= 1'b0;
      lat_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= commit_o;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LOW;
          bit_q   <= '0;
        end
        ST_LOW: if (tick_i) begin
          sck_q   <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (tick_i) begin
          sck_q <= 1'b0;
          if (bit_q == BW'(W - 1)) begin
            state_q <= ST_PRE;
          end else begin
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_LOW;
          end
        end
        // one low half period after the last fall before latching
        ST_PRE: if (tick_i) begin
          lat_q   <= 1'b1;
          state_q <= ST_LATCH;
        end
        ST_LATCH: if (tick_i) begin
          lat_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_chain_shreg.sv
module spi_chain_shreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  input  logic         capture_i,
  input  logic         commit_i,
  input  logic         sdi_i,
  output logic         sdo_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] tx_q, rx_q, rd_q;

  assign sdo_o   = tx_q[W-1];
  assign rdata_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
      rd_q <= '0;
    end else begin
      if (load_i)         tx_q <= data_i;
      else if (shift_i)   tx_q <= {tx_q[W-2:0], 1'b0};
      // sampled on the edge that raises sck, before the chain moves
      if (capture_i)      rx_q <= {rx_q[W-2:0], sdi_i};
      if (commit_i)       rd_q <= rx_q;
    end
  end
endmodule

// File: rtl/spi_chain_driver.sv
module spi_chain_driver #(
  parameter int unsigned N_DEV    = 2,
  parameter int unsigned HALF_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [8*N_DEV-1:0] data_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic               sck_o,
  output logic               lat_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [8*N_DEV-1:0] rdata_o
);
  localparam int unsigned W = 8 * N_DEV;

  logic tick, load, capture, shift, commit;

  spi_chain_tick #(.HALF(HALF_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_o),
    .tick_o (tick)
  );

  spi_chain_seq #(.W(W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .tick_i    (tick),
    .busy_o    (busy_o),
    .sck_o     (sck_o),
    .lat_o     (lat_o),
    .done_o    (done_o),
    .load_o    (load),
    .capture_o (capture),
    .shift_o   (shift),
    .commit_o  (commit)
  );

  spi_chain_shreg #(.W(W)) u_shreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .data_i    (data_i),
    .shift_i   (shift),
    .capture_i (capture),
    .commit_i  (commit),
    .sdi_i     (sdi_i),
    .sdo_o     (sdo_o),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/spi_chain_driver_chk.sv
module spi_chain_driver_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         sdo_o,
  input logic         sck_o,
  input logic         lat_o,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] rdata_o
);
  AST_SDO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(sdo_o)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sck_o && !lat_o)); // R4
  AST_LAT_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_o |-> !sck_o); // R5
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o)); // R7
  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $fell(lat_o))); // R8
endmodule

bind spi_chain_driver spi_chain_driver_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .sdo_o   (sdo_o),
  .sck_o   (sck_o),
  .lat_o   (lat_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .rdata_o (rdata_o)
);

// File: tb/sim_spi_chain_driver.sv
`timescale 1ns/1ps
module sim_spi_chain_driver;
  localparam int N_DEV = 2;
  localparam int HALF  = 4;
  localparam int W     = 8 * N_DEV;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] data = '0;
  logic         sdi, sdo, sck, lat, busy, done;
  logic [W-1:0] rdata;

  always #4 clk = ~clk;

  spi_chain_driver #(.N_DEV(N_DEV), .HALF_CYC(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data), .sdi_i(sdi),
    .sdo_o(sdo), .sck_o(sck), .lat_o(lat), .busy_o(busy), .done_o(done),
    .rdata_o(rdata)
  );

  // behavioural chain of latch devices
  logic [W-1:0] chain_q = '0;
  logic [W-1:0] par_q   = '0;
  always @(posedge sck) chain_q <= {chain_q[W-2:0], sdo};
  always @(posedge lat) par_q   <= chain_q;
  assign sdi = chain_q[W-1];

  int tests = 0, fails = 0;

  // port monitor, sampled on falling system clock edges
  logic p_sck = 0, p_lat = 0, p_sdo = 0, p_busy = 0;
  int hcnt = 0, lcnt = 0, rises = 0, lat_rises = 0, dones = 0;
  int e_half = 0, e_setup = 0, e_latpos = 0, e_latw = 0;

  always @(negedge clk) begin
    if (busy && !p_busy) hcnt = 1;
    else if (sck != p_sck) begin
      if (hcnt != HALF) e_half++;
      hcnt = 1;
      if (sck) rises++;
    end else hcnt++;
    if (sck && sdo != p_sdo) e_setup++;
    if (lat && !p_lat) begin
      lat_rises++;
      if (sck || rises != W) e_latpos++;
      lcnt = 1;
    end else if (lat) lcnt++;
    if (!lat && p_lat && lcnt != HALF) e_latw++;
    if (done) dones++;
    p_sck = sck; p_lat = lat; p_sdo = sdo; p_busy = busy;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic mon_clear();
    @(posedge clk);
    rises = 0; lat_rises = 0; dones = 0;
    e_half = 0; e_setup = 0; e_latpos = 0; e_latw = 0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_reset();
    #1;
    chk(!sck && !lat && !busy && !done, "R1", "lines in reset",
        {sck, lat, busy, done}, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sck && !lat && !busy && !done, "R1", "lines after reset",
        {sck, lat, busy, done}, '0);
    chk(rdata == '0, "R1", "rdata after reset", rdata, '0);
  endtask

  task automatic t_transfer(input logic [W-1:0] word);
    logic [W-1:0] prev;
    int cyc;
    prev = chain_q;
    mon_clear();
    @(negedge clk); start = 1'b1; data = word;
    @(negedge clk); start = 1'b0; data = ~word;
    chk(busy, "R6", "busy after start", busy, 1);
    wait_done(cyc);
    chk(done && !busy && !lat, "R8", "done with busy low", {done, busy, lat}, 3'b100);
    chk(par_q == word, "R2", "chain outputs", par_q, word);
    chk(rdata == prev, "R7", "readback", rdata, prev);
    chk(rises == W, "R2", "rising sck count", rises, W);
    chk(e_half == 0, "R4", "half period errors", e_half, 0);
    chk(e_setup == 0, "R3", "sdo change while sck high", e_setup, 0);
    chk(lat_rises == 1 && e_latpos == 0 && e_latw == 0, "R5", "latch pulse",
        {lat_rises[3:0], e_latpos[3:0], e_latw[3:0]}, {4'd1, 8'd0});
    @(negedge clk);
    chk(!done && dones == 1, "R8", "done width", dones, 1);
  endtask

  task automatic t_ignore_start(input logic [W-1:0] w1, input logic [W-1:0] w2);
    int cyc;
    mon_clear();
    @(negedge clk); start = 1'b1; data = w1;
    @(negedge clk); start = 1'b0;
    repeat (25) @(negedge clk);
    start = 1'b1; data = w2;
    @(negedge clk); start = 1'b0;
    wait_done(cyc);
    repeat (HALF * 4) @(negedge clk);
    chk(par_q == w1, "R6", "start while busy ignored", par_q, w1);
    chk(dones == 1 && !busy, "R6", "single transfer", dones, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_transfer(16'hA5C3);
    t_transfer(16'h0000);
    t_transfer(16'hFFFF);
    t_transfer(16'h8001);
    t_ignore_start(16'h1234, 16'hBEEF);
    t_transfer(16'h5A0F);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule